// File: doc/BRIEF.md
# Rank Idle-Period Averager

This block watches the read traffic of one memory rank and learns how long the rank typically stays quiet between reads. A counter measures each idle period, in memory clocks, from one read to the next. Every read closes the current period and adds its length into a running sum. Once a fixed window of idle periods has been summed, the block publishes their mean as a maximum-delay value. A refresh scheduler can then use that value to decide how long an idle gap must last before it issues a postponed refresh.

The mean needs no divider. A window always holds exactly 2^WIN_LOG2 periods, so the mean is the sum shifted right by WIN_LOG2, which is just a slice of the sum's upper bits. When a window completes, the sum and the period counter clear together, so each window stands on its own. The published value is updated with a one-cycle strobe. It keeps a programmable default until the first window has finished.

Top module: `rank_idle_avg`

## Requirements
- R1: The idle length that a read closes equals the number of clock cycles in which `read_sent_i` was low since the previous read, or since reset was released if there was no previous read.
- R2: An idle length stops counting at 2^CNT_W-1 and holds that value until the next read. It never wraps.
- R3: On the 2^WIN_LOG2-th read of a window, `max_delay_o` becomes floor(S / 2^WIN_LOG2), where S is the sum of that window's idle lengths. The new value is visible in the cycle after the closing read.
- R4: The running sum stops at 2^ACC_W-1. A window whose sum would pass that limit publishes all ones on `max_delay_o`.
- R5: Completing a window clears the sum and the period count. The next window's result depends only on its own idle lengths.
- R6: After reset, and until the first window completes, `max_delay_o` equals RST_DELAY and `avg_valid_o` is low.
- R7: `avg_valid_o` is high for exactly the one cycle after each window-closing read and is low at all other times. `max_delay_o` changes only in cycles where `avg_valid_o` is high.
- R8: Reads in consecutive cycles contribute an idle length of zero for every read after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| read_sent_i | input | 1 | High for each cycle in which a read is issued to the rank |
| max_delay_o | output | ACC_W-WIN_LOG2 | Mean idle length of the last completed window |
| avg_valid_o | output | 1 | One-cycle strobe that marks an update of `max_delay_o` |

## Verification
The assertions assume that `read_sent_i` is a clean synchronous level, sampled once per clock, and that reset stays low for at least one clock edge, so that every counter starts from zero. The properties that look at history also require that reset was high in the previous cycle. The bench drives `read_sent_i` only on falling edges and releases reset on a falling edge, so each read is seen at exactly one rising edge. It runs a small configuration and sweeps idle gaps from zero up past the counter ceiling. It also drives windows of mixed gaps and applies a reset in the middle of a run, so that both saturation limits and the window restart are reached.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int unsigned RID_CNT_W    = 14;
  localparam int unsigned RID_ACC_W    = 20;
  localparam int unsigned RID_WIN_LOG2 = 10;
  localparam int unsigned RID_RST_DLY  = 256;
endpackage

// File: rtl/rid_idle_cnt.sv
module rid_idle_cnt #(
  parameter int unsigned CNT_W = rid_pkg::RID_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_i,
  output logic [CNT_W-1:0] idle_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               idle_q <= '0;
    else if (read_i)           idle_q <= '0;
    else if (idle_q != CntMax) idle_q <= idle_q + 1'b1;
  end

  assign idle_o = idle_q;
endmodule

// File: rtl/rid_win_cnt.sv
module rid_win_cnt #(
  parameter int unsigned WIN_LOG2 = rid_pkg::RID_WIN_LOG2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                read_i,
  output logic [WIN_LOG2-1:0] win_o,
  output logic                done_o
);
  logic [WIN_LOG2-1:0] win_q;
  logic [WIN_LOG2-1:0] win_inc;
  logic                carry;

  // the carry out of the increment marks the last event of a window
  assign {carry, win_inc} = {1'b0, win_q} + {{WIN_LOG2{1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (read_i) win_q <= win_inc;
  end

  assign done_o = read_i & carry;
  assign win_o  = win_q;
endmodule

// File: rtl/rid_accum.sv
module rid_accum #(
  parameter int unsigned CNT_W = rid_pkg::RID_CNT_W,
  parameter int unsigned ACC_W = rid_pkg::RID_ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] idle_i,
  output logic [ACC_W-1:0] sum_o
);
  localparam int unsigned     SumW   = ((ACC_W > CNT_W) ? ACC_W : CNT_W) + 1;
  localparam logic [SumW-1:0] AccMax = SumW'({ACC_W{1'b1}});

  logic [ACC_W-1:0] acc_q;
  logic [SumW-1:0]  raw;

  assign raw   = SumW'(acc_q) + SumW'(idle_i);
  assign sum_o = (raw > AccMax) ? {ACC_W{1'b1}} : ACC_W'(raw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (read_i)  acc_q <= clear_i ? '0 : sum_o;
  end
endmodule

// File: rtl/rid_avg_reg.sv
module rid_avg_reg #(
  parameter int unsigned ACC_W     = rid_pkg::RID_ACC_W,
  parameter int unsigned WIN_LOG2  = rid_pkg::RID_WIN_LOG2,
  parameter int unsigned RST_DELAY = rid_pkg::RID_RST_DLY,
  localparam int unsigned AVG_W    = ACC_W - WIN_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [ACC_W-1:0] sum_i,
  output logic [AVG_W-1:0] avg_o,
  output logic             valid_o
);
  logic [AVG_W-1:0] avg_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q   <= AVG_W'(RST_DELAY);
      valid_q <= 1'b0;
    end else begin
      valid_q <= done_i;
      if (done_i) avg_q <= AVG_W'(sum_i >> WIN_LOG2);
    end
  end

  assign avg_o   = avg_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/rank_idle_avg.sv
module rank_idle_avg #(
  parameter int unsigned CNT_W     = rid_pkg::RID_CNT_W,
  parameter int unsigned ACC_W     = rid_pkg::RID_ACC_W,
  parameter int unsigned WIN_LOG2  = rid_pkg::RID_WIN_LOG2,
  parameter int unsigned RST_DELAY = rid_pkg::RID_RST_DLY,
  localparam int unsigned AVG_W    = ACC_W - WIN_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_sent_i,
  output logic [AVG_W-1:0] max_delay_o,
  output logic             avg_valid_o
);
  logic [CNT_W-1:0]    idle_q;
  logic [WIN_LOG2-1:0] win_q;
  logic [ACC_W-1:0]    sum_next;
  logic                win_done;

  rid_idle_cnt #(.CNT_W(CNT_W)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .read_i (read_sent_i),
    .idle_o (idle_q)
  );

  rid_win_cnt #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .read_i (read_sent_i),
    .win_o  (win_q),
    .done_o (win_done)
  );

  rid_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .read_i  (read_sent_i),
    .clear_i (win_done),
    .idle_i  (idle_q),
    .sum_o   (sum_next)
  );

  rid_avg_reg #(
    .ACC_W(ACC_W), .WIN_LOG2(WIN_LOG2), .RST_DELAY(RST_DELAY)
  ) u_avg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (win_done),
    .sum_i   (sum_next),
    .avg_o   (max_delay_o),
    .valid_o (avg_valid_o)
  );
endmodule

// File: rtl/rid_chk.sv
module rid_chk #(
  parameter int unsigned CNT_W    = 14,
  parameter int unsigned WIN_LOG2 = 10,
  parameter int unsigned AVG_W    = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                read_i,
  input logic [CNT_W-1:0]    idle_q,
  input logic [WIN_LOG2-1:0] win_q,
  input logic                valid_o,
  input logic [AVG_W-1:0]    max_delay_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  // R7: strobe never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7: strobe only follows a read
  a_r7_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && valid_o) |-> $past(read_i));

  // R7: output holds between strobes
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !valid_o) |-> $stable(max_delay_o));

  // R1: idle count advances while no read
  a_r1_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(read_i) && $past(idle_q) != CntMax)
      |-> idle_q == $past(idle_q) + 1'b1);

  // R8: a read restarts the idle count
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(read_i)) |-> idle_q == '0);

  // R2: idle count holds at its ceiling
  a_r2_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(read_i) && $past(idle_q) == CntMax)
      |-> idle_q == CntMax);

  // R5: window count is back at zero when a result is published
  a_r5_window_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> win_q == '0);
endmodule

bind rank_idle_avg rid_chk #(
  .CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2), .AVG_W(AVG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .read_i      (read_sent_i),
  .idle_q      (idle_q),
  .win_q       (win_q),
  .valid_o     (avg_valid_o),
  .max_delay_o (max_delay_o)
);

// File: tb/sim_rank_idle_avg.sv
`timescale 1ns/1ps
module sim_rank_idle_avg;
  localparam int CW = 5, AW = 7, WL = 3, RD = 9;
  localparam int OW = AW - WL;
  localparam int IMAX = (1 << CW) - 1;
  localparam int AMAX = (1 << AW) - 1;
  localparam int NWIN = 1 << WL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd = 1'b0;
  logic [OW-1:0] md;
  logic          vld;

  always #2.5 clk = ~clk;

  rank_idle_avg #(.CNT_W(CW), .ACC_W(AW), .WIN_LOG2(WL), .RST_DELAY(RD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .read_sent_i(rd),
    .max_delay_o(md), .avg_valid_o(vld)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;
  int m_cnt, m_sum, m_n;
  int e_md;
  bit e_val, any_done, win_sat, last_sat;
  string ctx = "R6 reset";

  task automatic check_outputs();
    vectors++;
    if (vld !== e_val) begin
      miscompares++;
      $display("FAIL R7 [%s] valid actual=%0b expected=%0b", ctx, vld, e_val);
    end
    vectors++;
    if (md !== OW'(e_md)) begin
      miscompares++;
      $display("FAIL %s [%s] max_delay actual=%0d expected=%0d",
               !any_done ? "R6" : (last_sat ? "R4" : "R3"), ctx, md, e_md);
    end
  endtask

  task automatic cyc(input bit r);
    @(negedge clk);
    check_outputs();
    rd = r;
    if (r) begin
      if (m_sum + m_cnt > AMAX) begin m_sum = AMAX; win_sat = 1'b1; end
      else m_sum = m_sum + m_cnt;
      m_cnt = 0;
      m_n++;
      if (m_n == NWIN) begin
        e_md = m_sum >> WL; e_val = 1'b1; any_done = 1'b1;
        last_sat = win_sat; win_sat = 1'b0; m_sum = 0; m_n = 0;
      end else e_val = 1'b0;
    end else begin
      e_val = 1'b0;
      m_cnt = (m_cnt < IMAX) ? m_cnt + 1 : IMAX;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd = 1'b0;
    m_cnt = 0; m_sum = 0; m_n = 0; e_md = RD; e_val = 1'b0;
    any_done = 1'b0; win_sat = 1'b0; last_sat = 1'b0;
    ctx = "R6 reset";
    repeat (2) @(negedge clk);
    check_outputs();
    rst_n = 1'b1;
    m_cnt = 1;  // counted by the first edge after release
  endtask

  task automatic window_const(input int g);
    for (int k = 0; k < NWIN; k++) begin
      repeat (g) cyc(1'b0);
      cyc(1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2 R8 R4: constant gaps across and past the idle ceiling
    for (int g = 0; g <= IMAX + 9; g++) begin
      if (g == 0)         ctx = "R8 back-to-back";
      else if (g > IMAX)  ctx = "R2 idle ceiling";
      else                ctx = "R1 gap sweep";
      window_const(g);
    end
    // R5: windows of mixed gaps, each independent of the last
    ctx = "R5 window restart";
    for (int w = 0; w < 12; w++)
      for (int k = 0; k < NWIN; k++) begin
        repeat ((k * 5 + w * 3) % 23) cyc(1'b0);
        cyc(1'b1);
      end
    // R6: reset in mid-window, then a fresh window
    repeat (3) begin repeat (4) cyc(1'b0); cyc(1'b1); end
    do_reset();
    ctx = "R6 after mid-run reset";
    repeat (6) cyc(1'b0);
    ctx = "R3 post-reset window";
    window_const(7);
    repeat (3) cyc(1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule